// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counters, each built from an 8-bit low and an 8-bit high count register. A 3-bit mode code picks how each timer counts. The codes are a 13-bit counter whose low five bits act as a prescale field, a 16-bit cascaded counter, an 8-bit counter that reloads itself from the high register, and a split mode in which timer 0 becomes two independent 8-bit counters. Each timer counts either system clock cycles or falling edges on its own count pin. An external level pin can hold the count while that timer's gate bit is set.

Software reaches the block through a flat single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the current address. When a timer's count wraps, it raises its overflow flag. Software clears a flag by writing 0 to it. In split mode, the upper half of timer 0 borrows timer 1's run bit and overflow flag, and timer 1 stops counting.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After reset every register reads 0, both overflow flags are 0, and no count changes until software writes.
- R2: The register map is as follows.
  - Address 0 is the mode register. For timer 0, bits [1:0] are the low code bits, bit 2 selects the source and bit 3 is the gate. Timer 1 uses bits [5:4], 6 and 7 in the same way.
  - Address 1 is the control register. Bit 0 and bit 1 are the run bits of timer 0 and timer 1. Bit 2 and bit 3 are their overflow flags. Bits [7:4] read 0.
  - Address 2 is the auxiliary register. Bit 0 is the top code bit of timer 0 and bit 4 is the top code bit of timer 1. Its other bits read 0.
  - Addresses 3, 4, 5 and 6 are the low and high count registers of timer 0, then of timer 1. Address 7 reads 0.
  - A timer's code is {auxiliary bit, mode bit pair}.
- R3: Code 000 counts {high, low[4:0]} as a 13-bit value. Low[7:5] are left unchanged. The flag sets when the value wraps from all ones to zero.
- R4: Code 001 counts {high, low} as a 16-bit value with no prescale. The flag sets on the wrap from 0xFFFF to 0x0000.
- R5: Code 010 increments the low register. A count while the low register is 0xFF loads the low register from the high register and sets the flag. The high register does not change.
- R6: Split mode is timer 0 with code 011.
  - Timer 0's low register is an 8-bit wrap counter under timer 0's own controls, and it sets flag 0 on the wrap.
  - Timer 0's high register increments on every clock while run bit 1 is set, and its wrap sets flag 1.
  - Timer 1's count registers hold.
- R7: A timer counts only while its run bit is 1 and either its gate bit is 0 or its gate pin is high. The gate pin passes through two synchronizing flops.
- R8: With its source bit set, a timer counts once per falling edge of its count pin, after a two-flop synchronizer and an edge-detect flop. Each pin phase must last at least two clocks.
- R9: Codes 100, 101, 110 and 111 hold both count registers of that timer. Code 011 on timer 1 holds timer 1.
- R10: Writing 0 to a flag bit clears it, and writing 1 to it has no effect. An overflow in the same cycle as a clearing write leaves the flag set.
- R11: A software write to a count register takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| cnt_pin | input | 2 | External count inputs, index = timer |
| gate_pin | input | 2 | External gate inputs, index = timer |
| ovf_flag | output | 2 | Overflow flags, index = timer |

## Verification
The properties rest on two assumptions. The first is that no register write reaches the block during the two cycles after the reset input is released. The second is that the pins sit low while the internal reset is active. Under these conditions, the synchronizer and register state agree with a model that leaves reset one cycle after the input rises. The count pin is assumed to hold each level for at least two clocks. The stimulus changes pins and registers only on falling clock edges, keeps every count-pin phase at three clocks, and waits four idle cycles after reset before the first write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef logic [2:0] tcode_t;

  localparam tcode_t CODE_13B   = 3'b000;
  localparam tcode_t CODE_16B   = 3'b001;
  localparam tcode_t CODE_RLD   = 3'b010;
  localparam tcode_t CODE_SPLIT = 3'b011;

  localparam int unsigned ADR_MODE = 0;
  localparam int unsigned ADR_CTRL = 1;
  localparam int unsigned ADR_AUX  = 2;
  localparam int unsigned ADR_TL0  = 3;
  localparam int unsigned ADR_TH0  = 4;
  localparam int unsigned ADR_TL1  = 5;
  localparam int unsigned ADR_TH1  = 6;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level,
  output logic fall
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], pin_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign level = pipe_q[STAGES-1];
  assign fall  = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/tmr_count_step.sv
module tmr_count_step
  import tmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 5
) (
  input  tcode_t         code,
  input  logic           inc,
  input  logic [DW-1:0]  tl,
  input  logic [DW-1:0]  th,
  output logic [DW-1:0]  tl_nx,
  output logic [DW-1:0]  th_nx,
  output logic           ovf
);
  localparam int LW = DW + PRE_W;
  localparam int FW = 2 * DW;

  logic [LW-1:0] cat_pre;
  logic [FW-1:0] cat_full;

  assign cat_pre  = {th, tl[PRE_W-1:0]};
  assign cat_full = {th, tl};

  always_comb begin
    tl_nx = tl;
    th_nx = th;
    ovf   = 1'b0;
    if (inc) begin
      case (code)
        CODE_13B: begin
          {th_nx, tl_nx[PRE_W-1:0]} = cat_pre + LW'(1);
          ovf = &cat_pre;
        end
        CODE_16B: begin
          {th_nx, tl_nx} = cat_full + FW'(1);
          ovf = &cat_full;
        end
        CODE_RLD: begin
          if (&tl) begin
            tl_nx = th;
            ovf   = 1'b1;
          end else begin
            tl_nx = tl + DW'(1);
          end
        end
        CODE_SPLIT: begin
          tl_nx = tl + DW'(1);
          ovf   = &tl;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
  import tmr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int PRE_W       = 5,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    gate_pin,
  output logic [1:0]    ovf_flag
);
  localparam int NT = 2;
  localparam int FB = 4;   // nibble of the mode register per timer

  logic rst_int_n;

  logic [DW-1:0]          mode_q, mode_d;
  logic [NT-1:0]          run_q, run_d;
  logic [NT-1:0]          flag_q, flag_d;
  logic [NT-1:0]          aux_q, aux_d;
  logic [NT-1:0][DW-1:0]  tl_q, tl_d, tl_st;
  logic [NT-1:0][DW-1:0]  th_q, th_d, th_st;
  logic [NT-1:0]          ovf_st;
  tcode_t [NT-1:0]        code_w;
  logic [NT-1:0]          cnt_fall, gate_lvl, en_w, inc_w;
  logic [NT-1:0]          wr_tl, wr_th, flag_set;
  logic                   t0_split, hi_inc, hi_ovf;
  logic                   wr_mode, wr_ctrl, wr_aux;

  tmr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_int_n)
  );

  assign t0_split = (code_w[0] == CODE_SPLIT);
  assign hi_inc   = t0_split & run_q[1];
  assign hi_ovf   = hi_inc & (&th_q[0]);

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic cnt_lvl_unused;
    logic gate_fall_unused;
    logic src_sel, gate_bit, src_tick;

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt (
      .clk(clk), .rst_n(rst_int_n), .pin_in(cnt_pin[i]),
      .level(cnt_lvl_unused), .fall(cnt_fall[i])
    );
    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_gate (
      .clk(clk), .rst_n(rst_int_n), .pin_in(gate_pin[i]),
      .level(gate_lvl[i]), .fall(gate_fall_unused)
    );

    assign code_w[i] = {aux_q[i], mode_q[FB*i+1:FB*i]};
    assign src_sel   = mode_q[FB*i+2];
    assign gate_bit  = mode_q[FB*i+3];
    assign src_tick  = src_sel ? cnt_fall[i] : 1'b1;
    assign en_w[i]   = run_q[i] & (~gate_bit | gate_lvl[i]);

    if (i == 0) begin : g_t0
      assign inc_w[i] = en_w[i] & src_tick;
    end else begin : g_tn
      assign inc_w[i] = en_w[i] & src_tick & ~t0_split & (code_w[i] != CODE_SPLIT);
    end

    tmr_count_step #(.DW(DW), .PRE_W(PRE_W)) u_step (
      .code(code_w[i]), .inc(inc_w[i]), .tl(tl_q[i]), .th(th_q[i]),
      .tl_nx(tl_st[i]), .th_nx(th_st[i]), .ovf(ovf_st[i])
    );

    assign wr_tl[i] = reg_wr & (reg_addr == AW'(ADR_TL0 + 2*i));
    assign wr_th[i] = reg_wr & (reg_addr == AW'(ADR_TH0 + 2*i));
  end

  assign wr_mode = reg_wr & (reg_addr == AW'(ADR_MODE));
  assign wr_ctrl = reg_wr & (reg_addr == AW'(ADR_CTRL));
  assign wr_aux  = reg_wr & (reg_addr == AW'(ADR_AUX));

  assign flag_set[0] = ovf_st[0];
  assign flag_set[1] = ovf_st[1] | hi_ovf;

  // next-state
  always_comb begin
    mode_d = wr_mode ? reg_wdata : mode_q;
    run_d  = wr_ctrl ? reg_wdata[1:0] : run_q;
    aux_d  = wr_aux  ? {reg_wdata[FB], reg_wdata[0]} : aux_q;
    for (int i = 0; i < NT; i++) begin
      flag_d[i] = flag_set[i] | (flag_q[i] & ~(wr_ctrl & ~reg_wdata[2+i]));
      tl_d[i]   = wr_tl[i] ? reg_wdata : tl_st[i];
    end
    th_d[0] = wr_th[0] ? reg_wdata : (hi_inc ? th_q[0] + DW'(1) : th_st[0]);
    th_d[1] = wr_th[1] ? reg_wdata : th_st[1];
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      aux_q  <= '0;
      tl_q   <= '0;
      th_q   <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      aux_q  <= aux_d;
      tl_q   <= tl_d;
      th_q   <= th_d;
    end
  end

  // read port
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(ADR_MODE): reg_rdata = mode_q;
      AW'(ADR_CTRL): reg_rdata = DW'({flag_q, run_q});
      AW'(ADR_AUX):  reg_rdata = DW'({aux_q[1], 3'b000, aux_q[0]});
      AW'(ADR_TL0):  reg_rdata = tl_q[0];
      AW'(ADR_TH0):  reg_rdata = th_q[0];
      AW'(ADR_TL1):  reg_rdata = tl_q[1];
      AW'(ADR_TH1):  reg_rdata = th_q[1];
      default:       reg_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          wd_flag0,
  input tcode_t        code0,
  input logic          inc0,
  input logic          run0,
  input logic          flag0,
  input logic [DW-1:0] tl0,
  input logic [DW-1:0] th0,
  input logic [DW-1:0] tl1,
  input logic [DW-1:0] th1
);
  logic w_tl0, w_th0, w_tl1, w_th1, w_clr0;
  assign w_tl0  = reg_wr && reg_addr == AW'(ADR_TL0);
  assign w_th0  = reg_wr && reg_addr == AW'(ADR_TH0);
  assign w_tl1  = reg_wr && reg_addr == AW'(ADR_TL1);
  assign w_th1  = reg_wr && reg_addr == AW'(ADR_TH1);
  assign w_clr0 = reg_wr && reg_addr == AW'(ADR_CTRL) && !wd_flag0;

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code0 == CODE_RLD && inc0 && (&tl0) && !w_tl0) |=> (tl0 == $past(th0)) && flag0);

  // R4
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code0 == CODE_16B && inc0 && (&{th0, tl0}) && !w_tl0 && !w_th0)
      |=> (tl0 == '0) && (th0 == '0) && flag0);

  // R9
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code0[2] && !w_tl0 && !w_th0) |=> $stable(tl0) && $stable(th0));

  // R6
  split_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code0 == CODE_SPLIT && !w_tl1 && !w_th1) |=> $stable(tl1) && $stable(th1));

  // R10
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag0) |-> $past(w_clr0));

  // R7
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !w_tl0) |=> $stable(tl0));
endmodule

bind dual_tmr_ctr tmr_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd_flag0(reg_wdata[2]), .code0(code_w[0]), .inc0(inc_w[0]),
  .run0(run_q[0]), .flag0(flag_q[0]),
  .tl0(tl_q[0]), .th0(th_q[0]), .tl1(tl_q[1]), .th1(th_q[1])
);

// File: tb/test_dual_tmr_ctr.sv
module test_dual_tmr_ctr;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_pin;
  logic [1:0] gate_pin;
  logic [1:0] ovf_flag;

  int checks = 0;
  int errors = 0;
  string phase = "R1 reset";

  dual_tmr_ctr i_dual_tmr_ctr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode, m_aux0, m_aux1;
  int m_run[2], m_flag[2], m_tl[2], m_th[2];
  int p1[4], p2[4], p3[4];   // pin pipelines: cnt0, cnt1, gate0, gate1

  function automatic int model_rd(input int a);
    case (a)
      0: return m_mode;
      1: return m_run[0] + 2*m_run[1] + 4*m_flag[0] + 8*m_flag[1];
      2: return m_aux0 + 16*m_aux1;
      3: return m_tl[0];
      4: return m_th[0];
      5: return m_tl[1];
      6: return m_th[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int code[2];
    int go[2];
    int ovf[2];
    int ntl[2];
    int nth[2];
    int v;
    if (!rst_n) begin
      m_mode = 0; m_aux0 = 0; m_aux1 = 0;
      for (int n = 0; n < 2; n++) begin
        m_run[n] = 0; m_flag[n] = 0; m_tl[n] = 0; m_th[n] = 0;
      end
      for (int k = 0; k < 4; k++) begin p1[k] = 0; p2[k] = 0; p3[k] = 0; end
    end else begin
      code[0] = m_aux0*4 + (m_mode % 4);
      code[1] = m_aux1*4 + ((m_mode / 16) % 4);
      for (int n = 0; n < 2; n++) begin
        int csel, gt;
        csel = (m_mode >> (4*n+2)) & 1;
        gt   = (m_mode >> (4*n+3)) & 1;
        go[n] = (m_run[n] == 1 && (gt == 0 || p2[2+n] == 1) &&
                 (csel == 0 || (p3[n] == 1 && p2[n] == 0))) ? 1 : 0;
        ovf[n] = 0; ntl[n] = m_tl[n]; nth[n] = m_th[n];
      end
      if (code[0] == 3 || code[1] == 3) go[1] = 0;
      for (int n = 0; n < 2; n++) begin
        if (go[n] == 1) begin
          case (code[n])
            0: begin
              v = m_th[n]*32 + (m_tl[n] % 32) + 1;
              if (v == 8192) begin v = 0; ovf[n] = 1; end
              ntl[n] = (m_tl[n] / 32)*32 + (v % 32);
              nth[n] = v / 32;
            end
            1: begin
              v = m_th[n]*256 + m_tl[n] + 1;
              if (v == 65536) begin v = 0; ovf[n] = 1; end
              ntl[n] = v % 256; nth[n] = v / 256;
            end
            2: begin
              if (m_tl[n] == 255) begin ntl[n] = m_th[n]; ovf[n] = 1; end
              else ntl[n] = m_tl[n] + 1;
            end
            3: begin
              if (m_tl[n] == 255) begin ntl[n] = 0; ovf[n] = 1; end
              else ntl[n] = m_tl[n] + 1;
            end
            default: ;
          endcase
        end
      end
      if (code[0] == 3 && m_run[1] == 1) begin
        if (m_th[0] == 255) begin nth[0] = 0; ovf[1] = 1; end
        else nth[0] = m_th[0] + 1;
      end
      if (reg_wr) begin
        case (int'(reg_addr))
          3: ntl[0] = reg_wdata;
          4: nth[0] = reg_wdata;
          5: ntl[1] = reg_wdata;
          6: nth[1] = reg_wdata;
          default: ;
        endcase
      end
      for (int n = 0; n < 2; n++) begin
        if (ovf[n] == 1) m_flag[n] = 1;
        else if (reg_wr && reg_addr == 3'd1 && reg_wdata[2+n] == 1'b0) m_flag[n] = 0;
        m_tl[n] = ntl[n]; m_th[n] = nth[n];
      end
      if (reg_wr && reg_addr == 3'd0) m_mode = reg_wdata;
      if (reg_wr && reg_addr == 3'd1) begin m_run[0] = reg_wdata[0]; m_run[1] = reg_wdata[1]; end
      if (reg_wr && reg_addr == 3'd2) begin m_aux0 = reg_wdata[0]; m_aux1 = reg_wdata[4]; end
      for (int k = 0; k < 4; k++) begin p3[k] = p2[k]; p2[k] = p1[k]; end
      p1[0] = cnt_pin[0]; p1[1] = cnt_pin[1]; p1[2] = gate_pin[0]; p1[3] = gate_pin[1];
    end
  end

  // per-clock comparison, away from the active edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check(int'(reg_rdata) == model_rd(int'(reg_addr)), {phase, " rdata"},
            reg_rdata, model_rd(int'(reg_addr)));
      check(int'(ovf_flag) == m_flag[0] + 2*m_flag[1], {phase, " flags"},
            ovf_flag, m_flag[0] + 2*m_flag[1]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic expect_rd(input int a, input int exp, input string tag);
    int v;
    rd(a, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R1..R11 incomplete): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, a0, b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cnt_pin = '0; gate_pin = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R1: reset values
    for (int a = 0; a < 8; a++) expect_rd(a, 0, "R1 reset register");
    check(ovf_flag == 2'b00, "R1 reset flags", ovf_flag, 0);

    // R2: register layout
    phase = "R2 layout";
    wr(0, 'hA5); expect_rd(0, 'hA5, "R2 mode readback");
    wr(2, 'hFF); expect_rd(2, 'h11, "R2 aux readback");
    wr(1, 'hFF); expect_rd(1, 'h03, "R10 flag write 1 ignored");
    wr(1, 0); wr(2, 0);

    // R4: 16-bit rollover
    phase = "R4 16-bit";
    wr(0, 'h01); wr(4, 'hFF); wr(3, 'hF0); wr(1, 'h01);
    idle(30);
    check(ovf_flag[0] == 1'b1, "R4 flag after wrap", ovf_flag[0], 1);
    expect_rd(4, 0, "R4 high after wrap");
    wr(1, 'h00);
    check(ovf_flag[0] == 1'b0, "R10 clear by write 0", ovf_flag[0], 0);

    // R3: 13-bit mode
    phase = "R3 13-bit";
    wr(0, 'h00); wr(4, 'hFF); wr(3, 'hF8); wr(1, 'h01);
    idle(20);
    wr(1, 'h04);
    check(ovf_flag[0] == 1'b1, "R3 flag after wrap", ovf_flag[0], 1);
    expect_rd(4, 0, "R3 high after wrap");
    rd(3, v);
    check((v & 'hE0) == 'hE0, "R3 low[7:5] untouched", v & 'hE0, 'hE0);

    // R5: auto-reload
    phase = "R5 reload";
    wr(1, 0); wr(0, 'h02); wr(4, 'hF0); wr(3, 'hFC); wr(1, 'h01);
    idle(40);
    wr(1, 'h04);
    check(ovf_flag[0] == 1'b1, "R5 flag on reload", ovf_flag[0], 1);
    expect_rd(4, 'hF0, "R5 high unchanged");
    rd(3, v);
    check(v >= 'hF0, "R5 low within reload range", v, 'hF0);

    // R10: set wins over clearing write
    phase = "R10 priority";
    wr(4, 'hFF); wr(3, 'hFF); wr(1, 'h01);
    wr(1, 'h01);
    check(ovf_flag[0] == 1'b1, "R10 set beats clear", ovf_flag[0], 1);
    wr(1, 'h00); wr(1, 'h00);
    check(ovf_flag[0] == 1'b0, "R10 clear when idle", ovf_flag[0], 0);

    // R11: count write beats counting
    phase = "R11 write priority";
    wr(0, 'h01); wr(4, 0); wr(1, 'h01);
    wr(3, 'h40); wr(1, 'h00);
    expect_rd(3, 'h42, "R11 loaded value then two counts");

    // R7: gating
    phase = "R7 gate";
    wr(0, 'h09); wr(3, 0); wr(4, 0); gate_pin[0] = 1'b0; wr(1, 'h01);
    idle(10);
    expect_rd(3, 0, "R7 gate low holds");
    gate_pin[0] = 1'b1;
    idle(10);
    rd(3, v);
    check(v != 0, "R7 gate high counts", v, 1);
    wr(1, 0); gate_pin[0] = 1'b0;

    // R8: external count pin
    phase = "R8 counter";
    wr(0, 'h05); wr(3, 0); wr(4, 0); wr(1, 'h01);
    for (int k = 0; k < 5; k++) begin
      cnt_pin[0] = 1'b1; idle(3);
      cnt_pin[0] = 1'b0; idle(3);
    end
    idle(4);
    expect_rd(3, 5, "R8 five falling edges");
    cnt_pin[0] = 1'b1; idle(12);
    expect_rd(3, 5, "R8 steady high no count");
    cnt_pin[0] = 1'b0; idle(4);
    wr(1, 0);

    // R6: split mode
    phase = "R6 split";
    wr(0, 'h13); wr(5, 'h10); wr(6, 'h20); wr(4, 'hFA); wr(3, 'hFD);
    wr(1, 'h03);
    idle(20);
    wr(1, 'h0C);
    check(ovf_flag == 2'b11, "R6 both flags routed", ovf_flag, 3);
    expect_rd(5, 'h10, "R6 timer1 low held");
    expect_rd(6, 'h20, "R6 timer1 high held");
    rd(4, v);
    check(v < 'h20, "R6 timer0 high wrapped", v, 'h20);

    // R9: reserved, PWM and timer 1 split code hold
    phase = "R9 hold";
    wr(1, 0); wr(2, 'h11); wr(0, 'h00); wr(1, 'h03);
    rd(3, a0); rd(5, b0);
    idle(10);
    expect_rd(3, a0, "R9 code 100 holds t0");
    expect_rd(5, b0, "R9 code 100 holds t1");
    wr(0, 'h22);
    idle(10);
    expect_rd(3, a0, "R9 code 110 holds t0");
    wr(1, 0); wr(2, 0); wr(0, 'h30); wr(1, 'h02);
    idle(10);
    expect_rd(5, b0, "R9 t1 code 011 holds");
    wr(0, 'h10); wr(1, 'h02);
    idle(10);
    rd(5, v);
    check(v != b0, "R9 t1 code 001 counts", v, b0 + 10);
    wr(1, 0);
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule